// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block controls an 8-bit successive-approximation analog-to-digital converter. On one side it has a small processor-style control interface: a start/busy bit, a result register and a completion flag. On the other side it drives an external sample-and-hold, a capacitive DAC, and a comparator whose decision it reads back. A start request stops sampling. After a short start delay the conversion clock begins. The block then resolves one bit per conversion-clock period, most significant bit first. At the end it loads the result, clears busy and raises the completion flag in the same cycle. The hold circuit returns to sampling one and a half conversion-clock periods later.

The conversion clock comes from one of two sources. It can be the system clock divided down to a period of 2, 8 or 32 system cycles. It can also be a free-running internal oscillator, which the block sees as a pulse at each of its half-period points. The sequencer counts time in conversion-clock half periods. One conversion spans 19 half periods, which is 9.5 periods. Software is responsible for meeting the acquisition time before each start.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy is 0, the completion flag is 0, the result is 0 and sampling is enabled.
- R2: A control write with the start bit at 1, made while idle, raises busy and stops sampling on the following clock edge. Sampling stays off for as long as busy is high.
- R3: With clock select 0, 1 or 2, the conversion half period is 1, 4 or 16 system cycles. Busy stays high for exactly 1 + 19 × (half period) cycles.
- R4: With clock select 3, the half-period pulses come from the internal oscillator, and a further 4 system cycles (one instruction cycle) are inserted before the conversion clock starts. Busy then lasts between 5 + 18·P + 1 and 5 + 19·P cycles, where P is the spacing of the oscillator pulses.
- R5: Bits are decided from bit 7 down to bit 0, one per conversion period. The DAC code shows the bits decided so far plus a 1 in the bit under trial. A comparator input of 1 keeps the trial bit. The result is the largest code whose DAC level the comparator accepts.
- R6: The result depends only on the input held when sampling stopped. Input changes during the conversion have no effect.
- R7: The result register keeps its old value for the whole conversion. It takes the new value in the same cycle that busy clears and the completion flag sets.
- R8: After completion, sampling re-enables exactly 3 conversion half periods later (1.5 periods).
- R9: A start write made while busy is ignored, and the conversion length is unchanged.
- R10: A write with the start bit at 0 during a conversion aborts it. Busy clears, sampling resumes, the result is unchanged and the completion flag is not set.
- R11: Only a control write with the flag bit at 0 clears the completion flag. A write with the flag bit at 1 leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe (one cycle) |
| ctl_go | input | 1 | Start/busy bit value written |
| ctl_flag | input | 1 | Completion flag value written (0 clears) |
| ctl_sel | input | 2 | Conversion clock select written (0..2 divided, 3 internal oscillator) |
| rc_tick | input | 1 | Internal oscillator half-period pulse |
| cmp_in | input | 1 | Comparator: 1 when held input is at or above the DAC level |
| busy | output | 1 | Conversion in progress (start/busy bit read-back) |
| done_flag | output | 1 | Completion flag |
| result | output | 8 | Result register |
| sample_en | output | 1 | 1 = sample-and-hold tracking, 0 = holding |
| dac_code | output | 8 | Trial code driven to the capacitive DAC |

## Verification
The bench counts busy cycles exactly in every divided mode, and within a window for the oscillator mode. A design that miscounts the 19 half periods or skips the start delay fails on the very first conversion. It moves the analog input in mid-conversion and reads the result register while busy is high, which exposes a hold that leaks or a result that is written early. It measures the tracking gap after each completion, so a design that resumes sampling at once is caught. It also pokes the start bit during a conversion and aborts another, which catches designs that restart, or that set the flag or overwrite the result on abort. It writes the flag with a 1 and then with a 0, and a design that clears the flag on any write fails that check.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2,
        ST_GAP  = 2'd3
    } state_e;

    localparam logic [1:0] SEL_OSC = 2'b11;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int HALF_A = 1,
    parameter int HALF_B = 4,
    parameter int HALF_C = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       rc_tick,
    output logic       half_tick
);
    import sar_pkg::*;

    localparam int CNT_W = $clog2(HALF_C + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic             hit;

    always_comb begin
        case (sel)
            2'd0:    limit = CNT_W'(HALF_A - 1);
            2'd1:    limit = CNT_W'(HALF_B - 1);
            default: limit = CNT_W'(HALF_C - 1);
        endcase
        hit       = (cnt_q == limit);
        half_tick = run && ((sel == SEL_OSC) ? rc_tick : hit);
        if (!run || sel == SEL_OSC || hit) cnt_d = '0;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int WIDTH = 8,
    parameter int HP_W  = 5
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [HP_W-1:0]  hp,
    input  logic             active,
    output logic [WIDTH-1:0] code
);
    logic [HP_W-1:0] pos;
    assign pos = hp >> 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign code[i] = acc[i] | (active && (pos == HP_W'(WIDTH - 1 - i)));
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int WIDTH     = 8,
    parameter int INSTR_CYC = 4,
    parameter int HALF_A    = 1,
    parameter int HALF_B    = 4,
    parameter int HALF_C    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_go,
    input  logic             ctl_flag,
    input  logic [1:0]       ctl_sel,
    input  logic             rc_tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done_flag,
    output logic [WIDTH-1:0] result,
    output logic             sample_en,
    output logic [WIDTH-1:0] dac_code
);
    import sar_pkg::*;

    localparam int HALVES    = 2 * WIDTH + 3;
    localparam int HP_W      = $clog2(HALVES);
    localparam int LAST_HP   = HALVES - 1;
    localparam int GAP_HALF  = 3;
    localparam int DLY_W     = $clog2(INSTR_CYC + 2);

    typedef struct packed {
        state_e           st;
        logic [DLY_W-1:0] dly;
        logic [HP_W-1:0]  hp;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] res;
        logic             flag;
        logic [1:0]       sel;
    } regs_t;

    regs_t q, d;
    logic  tick;
    logic  running;
    logic  is_busy;

    assign is_busy = (q.st == ST_WAIT) || (q.st == ST_CONV);
    assign running = (q.st == ST_CONV) || (q.st == ST_GAP);

    sar_tick_gen #(
        .HALF_A (HALF_A),
        .HALF_B (HALF_B),
        .HALF_C (HALF_C)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .sel       (q.sel),
        .rc_tick   (rc_tick),
        .half_tick (tick)
    );

    sar_trial #(
        .WIDTH (WIDTH),
        .HP_W  (HP_W)
    ) u_trial (
        .acc    (q.acc),
        .hp     (q.hp),
        .active (q.st == ST_CONV),
        .code   (dac_code)
    );

    always_comb begin
        d = q;
        if (ctl_wr && !ctl_flag) d.flag = 1'b0;
        if (ctl_wr && !is_busy)  d.sel  = ctl_sel;

        case (q.st)
            ST_IDLE, ST_GAP: begin
                if (ctl_wr && ctl_go) begin
                    d.st  = ST_WAIT;
                    d.dly = (ctl_sel == SEL_OSC) ? DLY_W'(INSTR_CYC + 1) : DLY_W'(1);
                    d.acc = '0;
                    d.hp  = '0;
                end else if (q.st == ST_GAP && tick) begin
                    if (q.hp == HP_W'(GAP_HALF - 1)) begin
                        d.st = ST_IDLE;
                        d.hp = '0;
                    end else begin
                        d.hp = q.hp + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (ctl_wr && !ctl_go) begin
                    d.st = ST_IDLE;
                end else if (q.dly == DLY_W'(1)) begin
                    d.st = ST_CONV;
                    d.hp = '0;
                end else begin
                    d.dly = q.dly - 1'b1;
                end
            end
            ST_CONV: begin
                if (ctl_wr && !ctl_go) begin
                    d.st = ST_IDLE;
                    d.hp = '0;
                end else if (tick) begin
                    if (q.hp == HP_W'(LAST_HP)) begin
                        d.res  = q.acc;
                        d.flag = 1'b1;
                        d.st   = ST_GAP;
                        d.hp   = '0;
                    end else begin
                        if (q.hp[0] && q.hp < HP_W'(2 * WIDTH)) begin
                            for (int i = 0; i < WIDTH; i++) begin
                                if ((q.hp >> 1) == HP_W'(WIDTH - 1 - i)) d.acc[i] = cmp_in;
                            end
                        end
                        d.hp = q.hp + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.dly  <= '0;
            q.hp   <= '0;
            q.acc  <= '0;
            q.res  <= '0;
            q.flag <= 1'b0;
            q.sel  <= 2'd0;
        end else begin
            q <= d;
        end
    end

    assign busy      = is_busy;
    assign done_flag = q.flag;
    assign result    = q.res;
    assign sample_en = (q.st == ST_IDLE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_go,
    input logic             ctl_flag,
    input logic             busy,
    input logic             done_flag,
    input logic [WIDTH-1:0] result,
    input logic             sample_en
);
    // R2
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sample_en);

    // R7
    result_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($fell(busy) && $rose(done_flag)));

    // R7
    flag_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));

    // R11
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(ctl_wr && !ctl_flag));

    // R10
    abort_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$rose(done_flag)) |-> $past(ctl_wr && !ctl_go));

    // R8
    gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $rose(done_flag)) |=> !sample_en);
endmodule

bind sar_seq sar_seq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_go    (ctl_go),
    .ctl_flag  (ctl_flag),
    .busy      (busy),
    .done_flag (done_flag),
    .result    (result),
    .sample_en (sample_en)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RC_HALF    = 6;
    localparam int INSTR      = 4;
    localparam int WDOG       = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_go = 1'b0;
    logic       ctl_flag = 1'b0;
    logic [1:0] ctl_sel = 2'd0;
    logic       rc_tick = 1'b0;
    logic       cmp_in;
    logic       busy;
    logic       done_flag;
    logic [7:0] result;
    logic       sample_en;
    logic [7:0] dac_code;

    logic [9:0] vin10 = '0;
    logic [9:0] held = '0;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    int         rc_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_go    (ctl_go),
        .ctl_flag  (ctl_flag),
        .ctl_sel   (ctl_sel),
        .rc_tick   (rc_tick),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .done_flag (done_flag),
        .result    (result),
        .sample_en (sample_en),
        .dac_code  (dac_code)
    );

    // analog model: track while enabled, compare held level against DAC level
    always @(posedge clk) if (sample_en) held <= vin10;
    assign cmp_in = (held >= {dac_code, 2'b00});

    always @(negedge clk) begin
        rc_cnt  <= (rc_cnt == RC_HALF - 1) ? 0 : rc_cnt + 1;
        rc_tick <= (rc_cnt == RC_HALF - 1);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp below %0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 4;
            default: return 16;
        endcase
    endfunction

    function automatic int exp_code(input logic [9:0] v);
        return int'(v >> 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit go, input bit flag, input logic [1:0] sel);
        ctl_wr = 1'b1; ctl_go = go; ctl_flag = flag; ctl_sel = sel;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_conv(input logic [9:0] v, input logic [1:0] sel, input bit poke);
        logic [7:0] prev;
        int len;
        int gap;
        int exp;
        prev  = result;
        vin10 = v;
        exp   = exp_code(v);
        wr(1'b1, 1'b0, sel);
        check(busy && !sample_en, "R2", {busy, sample_en}, 2);
        len = 1;
        while (busy && len < 2000) begin
            if (len == 5)  check(result == prev, "R7", result, prev);
            if (len == 20) vin10 = 10'($urandom % 1024); // R6 disturbance
            ctl_wr = (poke && len == 10); ctl_go = 1'b1; ctl_flag = 1'b0;
            @(negedge clk);
            ctl_wr = 1'b0;
            if (busy) len++;
        end
        check(int'(result) == exp, "R5/R6", result, exp);
        check(done_flag == 1'b1, "R7", done_flag, 1);
        if (sel == 2'd3) begin
            check(len >= 1 + INSTR + 18 * RC_HALF + 1 && len <= 1 + INSTR + 19 * RC_HALF,
                  "R4", len, 1 + INSTR + 19 * RC_HALF);
        end else begin
            check(len == 1 + 19 * half_of(sel), poke ? "R9" : "R3", len, 1 + 19 * half_of(sel));
        end
        gap = 0;
        while (!sample_en && gap < 2000) begin
            gap++;
            @(negedge clk);
        end
        if (sel == 2'd3)
            check(gap >= 2 * RC_HALF + 1 && gap <= 3 * RC_HALF, "R8", gap, 3 * RC_HALF);
        else
            check(gap == 3 * half_of(sel), "R8", gap, 3 * half_of(sel));
    endtask

    initial begin
        logic [7:0] keep;
        void'($urandom(32'h5A3C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!busy && !done_flag && result == 8'd0 && sample_en, "R1",
              {busy, done_flag, sample_en}, 1);

        // directed corners across all clock choices
        do_conv(10'd0,    2'd0, 1'b0);
        do_conv(10'd1023, 2'd1, 1'b0);
        do_conv(10'd512,  2'd2, 1'b0);
        do_conv(10'd511,  2'd0, 1'b0);
        do_conv(10'd683,  2'd3, 1'b0);
        do_conv(10'd170,  2'd3, 1'b0);

        // R9: start re-written during conversions
        do_conv(10'd300, 2'd1, 1'b1);
        do_conv(10'd77,  2'd2, 1'b1);

        // R11: write with flag bit 1 keeps the flag, write with 0 clears it
        wr(1'b0, 1'b1, 2'd0);
        check(done_flag == 1'b1, "R11", done_flag, 1);
        wr(1'b0, 1'b0, 2'd0);
        check(done_flag == 1'b0, "R11", done_flag, 0);

        // R10: abort mid-conversion
        keep  = result;
        vin10 = 10'd900;
        wr(1'b1, 1'b0, 2'd2);
        repeat (50) @(negedge clk);
        wr(1'b0, 1'b1, 2'd2);
        check(!busy && sample_en, "R10", {busy, sample_en}, 1);
        repeat (400) @(negedge clk);
        check(result == keep, "R10", result, keep);
        check(done_flag == 1'b0, "R10", done_flag, 0);

        // random conversions
        for (int i = 0; i < 30; i++) begin
            do_conv(10'($urandom % 1024), 2'($urandom % 4), 1'($urandom % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule